// File: doc/BRIEF.md
# Control Word Decoder and Shared Bus Steering

This block keeps a 21-bit control word and turns it into the mode signals and bus steering of a cipher datapath. A new word is captured whenever the load strobe is high. Two registered stages then produce the decoded outputs. The first stage is the word register and the second is the output register.

The decoded outputs are the cipher direction, the 2-bit edge-option code, the chaining enable, the sync/async select and the 12-bit block count. They go to the neighbouring units.

The block also steers a 130-lane shared bus. The source is one of four: a 128-bit data word, a 130-bit key, the 21-bit control word itself, or a 128-bit memory word. Each source sits at the top (MSB end) of the bus. A per-lane enable mask marks which lanes are driven, and every lane that is not driven reads as zero.

An idle bit switches every lane off. A clear bit raises a register-clear request to the key and data registers and to the chaining logic, and it also switches every lane off.

Top module: `cw_steer`

## Requirements
- R1: While reset is high, and in the cycle after it is released, all lane enables are 0, the bus is 0 and the clear output is 0. The reset word has the idle bit set and all other bits 0.
- R2: The word loaded at a clock edge shows on the outputs after the following edge. The bit positions are: direction = bit 20 (0 encrypt, 1 decrypt), edge option = bits 18:17, chaining enable = bit 16, sync select = bit 15, block count = bits 11:0. The transfer type = bits 14:13 is also exported.
- R3: Transfer type 00 (data) enables lanes 129:2. The bus then carries the data input on lanes 129:2, and lanes 1:0 are 0.
- R4: Transfer type 01 (key) enables all 130 lanes, and the bus carries the key input.
- R5: Transfer type 10 (control) enables lanes 129:109. The bus carries the held control word on those lanes, and all other lanes are 0.
- R6: Transfer type 11 (memory) enables lanes 129:2, and the bus carries the memory input on those lanes.
- R7: When bit 12 (idle) is 1, all lane enables and all bus lanes are 0 for every transfer type.
- R8: When bit 19 (clear) is 1, the clear output is 1. It also takes priority over any transfer, so all lane enables and all bus lanes are 0.
- R9: While the load strobe is low, the held word does not change, whatever the word input does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cw_load_i | input | 1 | Capture the word input |
| cw_i | input | 21 | Control word input |
| data_i | input | 128 | Data word source |
| key_i | input | 130 | Key source |
| mem_i | input | 128 | Memory word source |
| dir_o | output | 1 | 0 encrypt, 1 decrypt |
| edge_opt_o | output | 2 | Edge-option code |
| chain_en_o | output | 1 | Chaining enable |
| sync_o | output | 1 | Sync/async select |
| blk_cnt_o | output | 12 | Block count or address |
| xfer_o | output | 2 | Transfer type |
| clr_o | output | 1 | Clear request to the key, data and chaining registers |
| lane_en_o | output | 130 | Per-lane drive enables |
| bus_o | output | 130 | Shared bus value, zero on lanes that are off |

## Verification
The bench builds the block with its default parameters: a 130-lane bus, a 128-bit data word, a 130-bit key, a 12-bit count field and an idle reset word. With these widths the key transfer fills the bus exactly. The data and memory transfers leave a 2-lane gap at the low end, and the control transfer leaves 109 lanes empty, so every mask edge can be checked against fixed bit positions.

The data, key and memory inputs use distinct patterns, and each one has its lowest lanes set. If the wrong source is chosen, or a lane leaks through the mask, the bus value changes where the bench can see it.

// File: rtl/cw_steer_pkg.sv
package cw_steer_pkg;
  localparam int CW_W  = 21;
  localparam int CNT_W = 12;

  localparam int B_DIR   = 20;
  localparam int B_CLR   = 19;
  localparam int B_EDGE  = 17;
  localparam int B_CHAIN = 16;
  localparam int B_SYNC  = 15;
  localparam int B_XFER  = 13;
  localparam int B_IDLE  = 12;

  typedef enum logic [1:0] {
    XFER_DATA = 2'b00,
    XFER_KEY  = 2'b01,
    XFER_CTRL = 2'b10,
    XFER_MEM  = 2'b11
  } xfer_e;

  typedef struct packed {
    logic             dir;
    logic             clr;
    logic [1:0]       edge_opt;
    logic             chain_en;
    logic             sync_sel;
    xfer_e            xfer;
    logic             idle;
    logic [CNT_W-1:0] cnt;
  } cw_fields_t;
endpackage

// File: rtl/cw_reg.sv
module cw_reg #(
  parameter int          W       = 21,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)       q <= RST_VAL;
    else if (load) q <= d;
  end
endmodule

// File: rtl/cw_field_decode.sv
module cw_field_decode
  import cw_steer_pkg::*;
(
  input  logic [CW_W-1:0] word,
  output cw_fields_t      f
);
  always_comb begin
    f.dir      = word[B_DIR];
    f.clr      = word[B_CLR];
    f.edge_opt = word[B_EDGE +: 2];
    f.chain_en = word[B_CHAIN];
    f.sync_sel = word[B_SYNC];
    f.xfer     = xfer_e'(word[B_XFER +: 2]);
    f.idle     = word[B_IDLE];
    f.cnt      = word[CNT_W-1:0];
  end
endmodule

// File: rtl/lane_mask_gen.sv
module lane_mask_gen #(
  parameter int BUS_W = 130,
  parameter int USED  = 128
) (
  output logic [BUS_W-1:0] mask
);
  localparam int LOW = BUS_W - USED;
  for (genvar i = 0; i < BUS_W; i++) begin : g_lane
    if (i >= LOW) begin : g_on
      assign mask[i] = 1'b1;
    end else begin : g_off
      assign mask[i] = 1'b0;
    end
  end
endmodule

// File: rtl/cw_steer.sv
module cw_steer
  import cw_steer_pkg::*;
#(
  parameter int               BUS_W    = 130,
  parameter int               DATA_W   = 128,
  parameter int               KEY_W    = 130,
  parameter logic [CW_W-1:0]  RST_WORD = 21'h001000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cw_load_i,
  input  logic [CW_W-1:0]   cw_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [KEY_W-1:0]  key_i,
  input  logic [DATA_W-1:0] mem_i,
  output logic              dir_o,
  output logic [1:0]        edge_opt_o,
  output logic              chain_en_o,
  output logic              sync_o,
  output logic [CNT_W-1:0]  blk_cnt_o,
  output logic [1:0]        xfer_o,
  output logic              clr_o,
  output logic [BUS_W-1:0]  lane_en_o,
  output logic [BUS_W-1:0]  bus_o
);
  logic [CW_W-1:0]  cw_q;
  cw_fields_t       fld;
  logic [BUS_W-1:0] m_data, m_key, m_ctrl;
  logic [BUS_W-1:0] mask_c, src_c;

  cw_reg #(.W(CW_W), .RST_VAL(RST_WORD)) u_reg (
    .clk(clk), .rst(rst), .load(cw_load_i), .d(cw_i), .q(cw_q)
  );

  cw_field_decode u_dec (.word(cw_q), .f(fld));

  lane_mask_gen #(.BUS_W(BUS_W), .USED(DATA_W)) u_m_data (.mask(m_data));
  lane_mask_gen #(.BUS_W(BUS_W), .USED(KEY_W))  u_m_key  (.mask(m_key));
  lane_mask_gen #(.BUS_W(BUS_W), .USED(CW_W))   u_m_ctrl (.mask(m_ctrl));

  always_comb begin
    src_c = '0;
    case (fld.xfer)
      XFER_DATA: begin
        src_c[BUS_W-1 -: DATA_W] = data_i;
        mask_c = m_data;
      end
      XFER_KEY: begin
        src_c[BUS_W-1 -: KEY_W] = key_i;
        mask_c = m_key;
      end
      XFER_CTRL: begin
        src_c[BUS_W-1 -: CW_W] = cw_q;
        mask_c = m_ctrl;
      end
      default: begin
        src_c[BUS_W-1 -: DATA_W] = mem_i;
        mask_c = m_data;
      end
    endcase
    if (fld.clr || fld.idle) mask_c = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_o      <= 1'b0;
      edge_opt_o <= '0;
      chain_en_o <= 1'b0;
      sync_o     <= 1'b0;
      blk_cnt_o  <= '0;
      xfer_o     <= '0;
      clr_o      <= 1'b0;
      lane_en_o  <= '0;
      bus_o      <= '0;
    end else begin
      dir_o      <= fld.dir;
      edge_opt_o <= fld.edge_opt;
      chain_en_o <= fld.chain_en;
      sync_o     <= fld.sync_sel;
      blk_cnt_o  <= fld.cnt;
      xfer_o     <= fld.xfer;
      clr_o      <= fld.clr;
      lane_en_o  <= mask_c;
      bus_o      <= src_c & mask_c;
    end
  end
endmodule

// File: rtl/cw_steer_chk.sv
module cw_steer_chk #(
  parameter int BUS_W = 130
) (
  input logic             clk,
  input logic             rst,
  input logic             cw_load_i,
  input logic [1:0]       xfer_o,
  input logic             clr_o,
  input logic [BUS_W-1:0] lane_en_o,
  input logic [BUS_W-1:0] bus_o
);
  // R3
  bus_masked_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_o & ~lane_en_o) == '0);

  // R8
  clear_blocks_lanes_chk: assert property (@(posedge clk) disable iff (rst)
    clr_o |-> lane_en_o == '0);

  // R4
  low_lanes_key_only_chk: assert property (@(posedge clk) disable iff (rst)
    (lane_en_o[1:0] != 2'b00) |-> xfer_o == 2'b01);

  // R5
  top_lane_first_chk: assert property (@(posedge clk) disable iff (rst)
    (lane_en_o != '0) |-> lane_en_o[BUS_W-1]);

  // R9
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (!cw_load_i && !$past(cw_load_i)) |=> $stable(lane_en_o));
endmodule

bind cw_steer cw_steer_chk #(.BUS_W(BUS_W)) u_chk (
  .clk(clk), .rst(rst), .cw_load_i(cw_load_i), .xfer_o(xfer_o),
  .clr_o(clr_o), .lane_en_o(lane_en_o), .bus_o(bus_o)
);

// File: tb/cw_steer_tb.sv
module cw_steer_tb_top;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst;
  logic         cw_load_i;
  logic [20:0]  cw_i;
  logic [127:0] data_i;
  logic [129:0] key_i;
  logic [127:0] mem_i;
  logic         dir_o, chain_en_o, sync_o, clr_o;
  logic [1:0]   edge_opt_o, xfer_o;
  logic [11:0]  blk_cnt_o;
  logic [129:0] lane_en_o, bus_o;

  int total = 0;
  int bad   = 0;

  localparam logic [129:0] M_DATA = {{128{1'b1}}, 2'b00};
  localparam logic [129:0] M_KEY  = {130{1'b1}};
  localparam logic [129:0] M_CTRL = {{21{1'b1}}, {109{1'b0}}};

  always #(CLK_PERIOD/2) clk = ~clk;

  cw_steer dut_i (
    .clk(clk), .rst(rst), .cw_load_i(cw_load_i), .cw_i(cw_i),
    .data_i(data_i), .key_i(key_i), .mem_i(mem_i),
    .dir_o(dir_o), .edge_opt_o(edge_opt_o), .chain_en_o(chain_en_o),
    .sync_o(sync_o), .blk_cnt_o(blk_cnt_o), .xfer_o(xfer_o),
    .clr_o(clr_o), .lane_en_o(lane_en_o), .bus_o(bus_o)
  );

  function automatic logic [20:0] mk(logic d, logic c, logic [1:0] e,
      logic ch, logic s, logic [1:0] x, logic idl, logic [11:0] n);
    return {d, c, e, ch, s, x, idl, n};
  endfunction

  task automatic check(string req, logic [129:0] act, logic [129:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(logic [20:0] w);
    @(negedge clk); cw_i = w; cw_load_i = 1'b1;
    @(negedge clk); cw_load_i = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset;
    rst = 1'b1; cw_load_i = 1'b0; cw_i = '0;
    repeat (3) @(negedge clk);
    check("R1 lanes in reset", lane_en_o, '0);
    check("R1 clr in reset", 130'(clr_o), '0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 lanes after reset", lane_en_o, '0);
    check("R1 bus after reset", bus_o, '0);
  endtask

  task automatic t_fields;
    apply(mk(1'b1, 1'b0, 2'b10, 1'b1, 1'b0, 2'b00, 1'b0, 12'hABC));
    check("R2 dir", 130'(dir_o), 130'(1));
    check("R2 edge", 130'(edge_opt_o), 130'(2));
    check("R2 chain", 130'(chain_en_o), 130'(1));
    check("R2 sync", 130'(sync_o), 130'(0));
    check("R2 count", 130'(blk_cnt_o), 130'(12'hABC));
    apply(mk(1'b0, 1'b0, 2'b01, 1'b0, 1'b1, 2'b00, 1'b0, 12'hFFF));
    check("R2 dir0", 130'(dir_o), 130'(0));
    check("R2 edge1", 130'(edge_opt_o), 130'(1));
    check("R2 sync1", 130'(sync_o), 130'(1));
    check("R2 count max", 130'(blk_cnt_o), 130'(12'hFFF));
  endtask

  task automatic t_data;
    apply(mk(1'b0, 1'b0, 2'b00, 1'b0, 1'b0, 2'b00, 1'b0, 12'd1));
    check("R3 data lanes", lane_en_o, M_DATA);
    check("R3 data bus", bus_o, {data_i, 2'b00});
  endtask

  task automatic t_key;
    apply(mk(1'b0, 1'b0, 2'b00, 1'b0, 1'b0, 2'b01, 1'b0, 12'd0));
    check("R4 key lanes", lane_en_o, M_KEY);
    check("R4 key bus", bus_o, key_i);
  endtask

  task automatic t_ctrl;
    logic [20:0] w;
    w = mk(1'b1, 1'b0, 2'b11, 1'b1, 1'b1, 2'b10, 1'b0, 12'h5A5);
    apply(w);
    check("R5 ctrl lanes", lane_en_o, M_CTRL);
    check("R5 ctrl bus", bus_o, {w, 109'b0});
  endtask

  task automatic t_mem;
    apply(mk(1'b0, 1'b0, 2'b00, 1'b0, 1'b0, 2'b11, 1'b0, 12'd7));
    check("R6 mem lanes", lane_en_o, M_DATA);
    check("R6 mem bus", bus_o, {mem_i, 2'b00});
  endtask

  task automatic t_idle;
    for (int x = 0; x < 4; x++) begin
      apply(mk(1'b0, 1'b0, 2'b00, 1'b0, 1'b0, 2'(x), 1'b1, 12'd3));
      check("R7 idle lanes", lane_en_o, '0);
      check("R7 idle bus", bus_o, '0);
    end
  endtask

  task automatic t_clear;
    apply(mk(1'b0, 1'b1, 2'b00, 1'b0, 1'b0, 2'b01, 1'b0, 12'd0));
    check("R8 clr out", 130'(clr_o), 130'(1));
    check("R8 lanes off", lane_en_o, '0);
    check("R8 bus off", bus_o, '0);
    apply(mk(1'b0, 1'b0, 2'b00, 1'b0, 1'b0, 2'b01, 1'b0, 12'd0));
    check("R8 clr released", 130'(clr_o), 130'(0));
  endtask

  task automatic t_hold;
    apply(mk(1'b0, 1'b0, 2'b00, 1'b0, 1'b0, 2'b01, 1'b0, 12'h123));
    @(negedge clk); cw_i = mk(1'b1, 1'b1, 2'b11, 1'b1, 1'b1, 2'b10, 1'b1, 12'hFFF);
    repeat (3) @(negedge clk);
    check("R9 hold lanes", lane_en_o, M_KEY);
    check("R9 hold count", 130'(blk_cnt_o), 130'(12'h123));
    check("R9 hold clr", 130'(clr_o), 130'(0));
  endtask

  initial begin
    data_i = {32'h0123_4567, 32'h89AB_CDEF, 32'hDEAD_BEEF, 32'h5555_AAA7};
    key_i  = {2'b10, 32'hC0DE_F00D, 32'h1357_9BDF, 32'h2468_ACE0, 32'h0F0F_F0F3};
    mem_i  = {32'hFEED_FACE, 32'h0BAD_CAFE, 32'h7777_1111, 32'h3C3C_C3C3};
    t_reset;
    t_fields;
    t_data;
    t_key;
    t_ctrl;
    t_mem;
    t_idle;
    t_clear;
    t_hold;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule